// File: doc/BRIEF.md
# Cartridge Bank-Select Latch

This block is the bank-switching logic of a game cartridge for an 8-bit console. It contains one latch register that the CPU writes to. The latched value chooses which 32 KiB bank of program ROM the CPU sees and which 8 KiB bank of character ROM the graphics side sees. The block drives the upper program ROM address lines, the upper character ROM address lines, and the active-low program ROM output enable.

The parameter `LAYOUT` selects one of three register layouts:

- **Layout 0 (narrow, in the ROM window).** The register answers writes anywhere in $8000-$FFFF. Only four bits are used: data bits 1:0 select the character bank and data bits 5:4 select the program bank. These two fields are not next to each other.
- **Layout 1 (low window).** The register answers writes in $6000-$7FFF. It takes the character bank from data bits 3:0 (16 banks) and the program bank from data bits 5:4.
- **Layout 2 (wide, nybble-swapped).** The register answers writes in $8000-$FFFF and uses all eight bits. The low nybble is the program bank (16 x 32 KiB) and the high nybble is the character bank (16 x 8 KiB).

When the register sits inside the ROM window, the ROM may still be driving the data bus during a CPU write. That collision is modelled as an open-drain AND: the value latched is the CPU data AND the ROM byte, which arrives on `rom_data`. Setting `CONFLICT_FREE` to 1 keeps the ROM output enable off during writes, so the CPU data is latched exactly.

A small strobe state machine runs on the fast system clock and follows the M2 strobe:

| State | Meaning | Transitions |
|-------|---------|-------------|
| `ST_IDLE` | M2 is low | go to `ST_ACTIVE` when M2 is seen high |
| `ST_ACTIVE` | M2 is high; the resolved bus value is captured every cycle | when M2 is seen low: go to `ST_LATCH` if the captured cycle was a write to the decoded window, otherwise go to `ST_IDLE` |
| `ST_LATCH` | the register loads the captured value | go to `ST_IDLE` unconditionally |

Top module: `cart_bank_mapper`

## Requirements
- R1: While `rst_n` is low, the register clears to zero on each clock, so `prg_bank` = 0 and `chr_bank` = 0.
- R2: In layout 0, `chr_bank` = latched bits 1:0 and `prg_bank` = latched bits 5:4. The upper output bits are 0, and latched bits 7:6 and 3:2 have no effect on either output.
- R3: In layout 1, `chr_bank` = latched bits 3:0 and `prg_bank` = latched bits 5:4.
- R4: In layout 2, `prg_bank` = latched bits 3:0 and `chr_bank` = latched bits 7:4.
- R5: Layouts 0 and 2 accept writes only when `cpu_addr[15]` = 1. Layout 1 accepts writes only when `cpu_addr[15:13]` = 3'b011. A write anywhere else leaves both outputs unchanged.
- R6: A read cycle (`cpu_rw` = 1) never changes the register in any layout.
- R7: A write is taken when M2 falls while `cpu_rw` = 0. Take the first clock edge that samples M2 low. The outputs still hold the old value just after that edge, and they show the new value just after the following edge.
- R8: In layouts 0 and 2 with `CONFLICT_FREE` = 0, the value latched is `cpu_data & rom_data`.
- R9: With `CONFLICT_FREE` = 1, the value latched is `cpu_data` exactly, and `prg_oe_n` never goes low during a write.
- R10: `prg_oe_n` is low while M2 is high, `cpu_addr[15]` = 1, and either `cpu_rw` = 1 or the configuration has conflicts (layout 0 or 2 with `CONFLICT_FREE` = 0). Otherwise `prg_oe_n` is high.
- R11: In layout 1, `rom_data` has no effect on the latched value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than M2 |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | Data the CPU drives during writes |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU bus strobe; high while the bus cycle is valid |
| rom_data | input | 8 | Byte the program ROM presents at `cpu_addr` |
| prg_bank | output | PRG_W | Upper program ROM address lines (32 KiB bank number) |
| chr_bank | output | CHR_W | Upper character ROM address lines (8 KiB bank number) |
| prg_oe_n | output | 1 | Program ROM output enable, active low |

## Verification
The bench builds four copies of the block and drives them from one shared bus:

- layout 0 with conflicts,
- layout 1,
- layout 2 with conflicts,
- layout 0 with `CONFLICT_FREE` = 1.

Every one of the 256 data values is written in the ROM window with a ROM byte that differs from the data. The same is then done in the low window. This brings, in one run, the AND-conflict result, the exact-value path, all three field mappings and both address decodes within reach. It also confirms that each copy ignores writes aimed at the other window, as well as writes below $6000 and reads.

// File: rtl/cart_mapper_pkg.sv
`timescale 1ns/1ps
package cart_mapper_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Register layout selector values
    localparam int LAYOUT_NARROW   = 0;
    localparam int LAYOUT_LOWWIN   = 1;
    localparam int LAYOUT_WIDESWAP = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_LATCH  = 2'd2
    } strobe_state_e;

    typedef struct packed {
        logic              wr;
        logic              hit;
        logic [DATA_W-1:0] data;
    } bus_snap_t;

    // True when the ROM still drives the data bus during a register write.
    function automatic bit rom_drives_on_write(int layout, bit conflict_free);
        return (layout != LAYOUT_LOWWIN) && !conflict_free;
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
`timescale 1ns/1ps
module cart_addr_decode
    import cart_mapper_pkg::*;
#(
    parameter int LAYOUT        = 0,
    parameter bit CONFLICT_FREE = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr_top,   // cpu_addr[15:13]
    input  logic       cpu_rw,
    input  logic       m2,
    output logic       reg_hit,
    output logic       rom_oe_n
);

    localparam bit DRIVE_ON_WR = rom_drives_on_write(LAYOUT, CONFLICT_FREE);

    logic in_rom;
    logic in_low;

    assign in_rom = addr_top[2];
    assign in_low = (addr_top == 3'b011);

    generate
        if (LAYOUT == LAYOUT_LOWWIN) begin : g_low_decode
            assign reg_hit = in_low;
        end else begin : g_rom_decode
            assign reg_hit = in_rom;
        end
    endgenerate

    always_comb begin
        rom_oe_n = 1'b1;
        if (m2 && in_rom && (cpu_rw || DRIVE_ON_WR)) begin
            rom_oe_n = 1'b0;
        end
    end

    // R10
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m2 && cpu_rw && addr_top[2]) |-> !rom_oe_n);

    // R10
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m2 || !addr_top[2]) |-> rom_oe_n);

endmodule

// File: rtl/cart_bus_resolve.sv
`timescale 1ns/1ps
module cart_bus_resolve
    import cart_mapper_pkg::*;
#(
    parameter int LAYOUT        = 0,
    parameter bit CONFLICT_FREE = 0
) (
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [DATA_W-1:0] rom_data,
    input  logic              rom_oe_n,
    output logic [DATA_W-1:0] eff_data
);

    localparam bit CAN_COLLIDE = rom_drives_on_write(LAYOUT, CONFLICT_FREE);

    generate
        if (CAN_COLLIDE) begin : g_wired_and
            // Open-drain model: either driver pulling low wins.
            always_comb begin
                eff_data = cpu_data;
                if (!rom_oe_n) begin
                    eff_data = cpu_data & rom_data;
                end
            end
        end else begin : g_clean
            logic unused_rom;
            assign unused_rom = ^{rom_data, rom_oe_n};
            assign eff_data   = cpu_data;
        end
    endgenerate

endmodule

// File: rtl/cart_strobe_fsm.sv
`timescale 1ns/1ps
module cart_strobe_fsm
    import cart_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              cpu_rw,
    input  logic              reg_hit,
    input  logic [DATA_W-1:0] eff_data,
    output logic [DATA_W-1:0] reg_q
);

    strobe_state_e state_q, state_d;
    bus_snap_t     snap_q;
    logic          load_en;

    // State register and bus snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (m2) begin
                snap_q.wr   <= !cpu_rw;
                snap_q.hit  <= reg_hit;
                snap_q.data <= eff_data;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (m2) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!m2) begin
                    state_d = (snap_q.wr && snap_q.hit) ? ST_LATCH : ST_IDLE;
                end
            end
            ST_LATCH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        load_en = 1'b0;
        unique case (state_q)
            ST_LATCH:  load_en = 1'b1;
            ST_IDLE,
            ST_ACTIVE: load_en = 1'b0;
            default:   load_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (load_en) begin
            reg_q <= snap_q.data;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0));

    // R5
    hold_unless_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LATCH) |=> $stable(reg_q));

    // R7
    latch_follows_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |-> ($past(state_q) == ST_ACTIVE && !$past(m2)));

endmodule

// File: rtl/cart_field_map.sv
`timescale 1ns/1ps
module cart_field_map
    import cart_mapper_pkg::*;
#(
    parameter int LAYOUT = 0,
    parameter int PRG_W  = 4,
    parameter int CHR_W  = 4
) (
    input  logic [DATA_W-1:0] reg_q,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_bank
);

    logic [3:0] prg_nyb;
    logic [3:0] chr_nyb;

    generate
        if (LAYOUT == LAYOUT_WIDESWAP) begin : g_wide
            assign prg_nyb = reg_q[3:0];
            assign chr_nyb = reg_q[7:4];
        end else if (LAYOUT == LAYOUT_LOWWIN) begin : g_low
            logic unused_bits;
            assign unused_bits = ^{reg_q[7:6]};
            assign prg_nyb = {2'b00, reg_q[5:4]};
            assign chr_nyb = reg_q[3:0];
        end else begin : g_narrow
            logic unused_bits;
            assign unused_bits = ^{reg_q[7:6], reg_q[3:2]};
            assign prg_nyb = {2'b00, reg_q[5:4]};
            assign chr_nyb = {2'b00, reg_q[1:0]};
        end
    endgenerate

    assign prg_bank = PRG_W'(prg_nyb);
    assign chr_bank = CHR_W'(chr_nyb);

endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
    import cart_mapper_pkg::*;
#(
    parameter int LAYOUT        = 0,
    parameter bit CONFLICT_FREE = 0,
    parameter int PRG_W         = 4,
    parameter int CHR_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    input  logic              m2,
    input  logic [7:0]        rom_data,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_bank,
    output logic              prg_oe_n
);

    logic              reg_hit;
    logic              rom_oe_n;
    logic [DATA_W-1:0] eff_data;
    logic [DATA_W-1:0] reg_q;
    logic              unused_addr;

    assign unused_addr = ^cpu_addr[12:0];

    cart_addr_decode #(
        .LAYOUT        (LAYOUT),
        .CONFLICT_FREE (CONFLICT_FREE)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_top (cpu_addr[15:13]),
        .cpu_rw   (cpu_rw),
        .m2       (m2),
        .reg_hit  (reg_hit),
        .rom_oe_n (rom_oe_n)
    );

    cart_bus_resolve #(
        .LAYOUT        (LAYOUT),
        .CONFLICT_FREE (CONFLICT_FREE)
    ) u_resolve (
        .cpu_data (cpu_data),
        .rom_data (rom_data),
        .rom_oe_n (rom_oe_n),
        .eff_data (eff_data)
    );

    cart_strobe_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .m2       (m2),
        .cpu_rw   (cpu_rw),
        .reg_hit  (reg_hit),
        .eff_data (eff_data),
        .reg_q    (reg_q)
    );

    cart_field_map #(
        .LAYOUT (LAYOUT),
        .PRG_W  (PRG_W),
        .CHR_W  (CHR_W)
    ) u_map (
        .reg_q    (reg_q),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );

    assign prg_oe_n = rom_oe_n;

    // R8
    wired_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rw && !prg_oe_n) |-> ((eff_data & ~rom_data) == '0));

    // R9
    generate
        if (CONFLICT_FREE) begin : g_cf_chk
            no_oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !prg_oe_n |-> cpu_rw);
        end
    endgenerate

endmodule

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        m2 = 1'b0;
    logic [7:0]  rom_data = '0;

    logic [3:0] prg_o [4];
    logic [3:0] chr_o [4];
    logic       oe_o  [4];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    logic [7:0] exp_reg [4];

    always #10 clk = ~clk;   // 50 MHz

    cart_bank_mapper #(.LAYOUT(0), .CONFLICT_FREE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .m2(m2), .rom_data(rom_data),
        .prg_bank(prg_o[0]), .chr_bank(chr_o[0]), .prg_oe_n(oe_o[0]));
    cart_bank_mapper #(.LAYOUT(1), .CONFLICT_FREE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .m2(m2), .rom_data(rom_data),
        .prg_bank(prg_o[1]), .chr_bank(chr_o[1]), .prg_oe_n(oe_o[1]));
    cart_bank_mapper #(.LAYOUT(2), .CONFLICT_FREE(0)) u2 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .m2(m2), .rom_data(rom_data),
        .prg_bank(prg_o[2]), .chr_bank(chr_o[2]), .prg_oe_n(oe_o[2]));
    cart_bank_mapper #(.LAYOUT(0), .CONFLICT_FREE(1)) u3 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .m2(m2), .rom_data(rom_data),
        .prg_bank(prg_o[3]), .chr_bank(chr_o[3]), .prg_oe_n(oe_o[3]));

    function automatic int lay_of(int i);
        return (i == 1) ? 1 : (i == 2) ? 2 : 0;
    endfunction

    function automatic bit collides(int i);
        return (i == 0) || (i == 2);
    endfunction

    function automatic logic [3:0] exp_prg(int i, logic [7:0] r);
        return (lay_of(i) == 2) ? r[3:0] : {2'b00, r[5:4]};
    endfunction

    function automatic logic [3:0] exp_chr(int i, logic [7:0] r);
        if (lay_of(i) == 0) return {2'b00, r[1:0]};
        if (lay_of(i) == 1) return r[3:0];
        return r[7:4];
    endfunction

    task automatic check_val(string req, int i, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s u%0d %s actual=%h expected=%h", req, i, what, act, exp);
        end
    endtask

    task automatic check_dut(int i, string req);
        check_val(req, i, "prg", prg_o[i], exp_prg(i, exp_reg[i]));
        check_val(req, i, "chr", chr_o[i], exp_chr(i, exp_reg[i]));
    endtask

    task automatic bus_cycle(logic [15:0] a, logic [7:0] d, logic [7:0] rd,
                             logic rw, string oe_req);
        bit hit;
        @(negedge clk);
        cpu_addr = a; cpu_data = d; rom_data = rd; cpu_rw = rw; m2 = 1'b1;
        repeat (2) @(negedge clk);
        // R10: output enable while strobe high
        for (int i = 0; i < 4; i++) begin
            logic exp_oe;
            exp_oe = !(a[15] && (rw || collides(i)));
            check_val(oe_req, i, "oe_n", {3'b0, oe_o[i]}, {3'b0, exp_oe});
        end
        @(negedge clk);
        m2 = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            hit = (lay_of(i) == 1) ? (a[15:13] == 3'b011) : a[15];
            if (!rw && hit) exp_reg[i] = collides(i) ? (d & rd) : d;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++) check_dut(i, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R7: exact cycle of the update (u3 latches data exactly)
        @(negedge clk);
        cpu_addr = 16'h8123; cpu_data = 8'h31; rom_data = 8'hFF; cpu_rw = 1'b0; m2 = 1'b1;
        repeat (3) @(negedge clk);
        m2 = 1'b0;
        @(negedge clk);   // first edge samples m2 low
        check_val("R7", 3, "prg_old", prg_o[3], 4'h0);
        @(negedge clk);
        check_val("R7", 3, "prg_new", prg_o[3], 4'h3);
        check_val("R7", 3, "chr_new", chr_o[3], 4'h1);
        repeat (3) @(negedge clk);
        exp_reg[0] = 8'h31; exp_reg[2] = 8'h31; exp_reg[3] = 8'h31;

        // Sweep in the ROM window, ROM byte differs from data
        for (int v = 0; v < 256; v++) begin
            logic [7:0] rb;
            rb = 8'(v * 37 + 91) ^ 8'hC3;
            bus_cycle(16'h8000 | 16'((v * 129) & 16'h7FFF), 8'(v), rb, 1'b0, "R10");
            check_dut(0, "R2_R8");
            check_dut(1, "R5");
            check_dut(2, "R4_R8");
            check_dut(3, "R9");
        end

        // Sweep in the low window
        for (int v = 0; v < 256; v++) begin
            logic [7:0] rb;
            rb = ~8'(v);
            bus_cycle(16'h6000 | 16'((v * 31) & 16'h1FFF), 8'(v), rb, 1'b0, "R10");
            check_dut(0, "R5");
            check_dut(1, "R3_R11");
            check_dut(2, "R5");
            check_dut(3, "R5");
        end

        // Writes below $6000: nobody responds
        for (int v = 0; v < 24; v++) begin
            bus_cycle(16'(v * 1000), 8'(v * 11 + 1), 8'hFF, 1'b0, "R10");
            for (int i = 0; i < 4; i++) check_dut(i, "R5");
        end

        // Reads in both windows never change the register
        for (int v = 0; v < 16; v++) begin
            bus_cycle(16'h8000 + 16'(v * 2048), 8'(v * 17), 8'h0F, 1'b1, "R10");
            bus_cycle(16'h6000 + 16'(v * 500), 8'(v * 13), 8'hF0, 1'b1, "R10");
            for (int i = 0; i < 4; i++) check_dut(i, "R6");
        end

        // Reset in mid-run clears the register
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
        for (int i = 0; i < 4; i++) check_dut(i, "R1");
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule